// File: doc/BRIEF.md
# Host Configuration Register Bank with Two-Level Reset

This block holds the configuration words that a host processor sets up before the rest of a chip is allowed to move traffic. The host reaches it through a plain 32-bit slave port with a word address, write data, four byte-enable lines and separate write and read strobes. Read data comes back on the cycle after the read strobe, flagged by a valid bit. Every register is 16 bits wide and sits in the low half of the bus word.

The bank answers to two kinds of reset. The reset pin clears everything direct. Software can also request a reset by setting bit 0 of the master control word. That request becomes a one-cycle internal pulse. The pulse clears every direct register except the bridge-mode word, which only the pin can clear. A 16-entry indirect table is reached through an index register and a data window. Neither reset ever touches that table, so its contents must be loaded by the host after power-up.

The block also drives a combined system reset to the rest of the chip, so that downstream engines stay idle during either kind of reset.

Top module: `cfg_host_regfile`

## Requirements
- R1: While the reset pin is low, `sys_rst` is 1. After the pin is released, word 0 reads 5A00h and words 1 to 6 read 0000h, including the bridge-mode word (word 1). `bus_rvalid` is 0.
- R2: The word map is fixed. Word 0 is the master control/ID word. Word 1 is bridge mode. Words 2 to 5 are general configuration. Word 6 is the indirect index, with the index in bits 3:0 and the busy flag in bit 15. Word 7 is the indirect data window. A write with any nonzero byte-enable pattern loads all 16 bits from `bus_wdata[15:0]`, and `bus_wdata[31:16]` is ignored.
- R3: An access whose four byte enables are all 0 has no effect. A write changes no register, and a read produces no `bus_rvalid`.
- R4: A read with a nonzero byte enable raises `bus_rvalid` on the next cycle. On that cycle the word appears on `bus_rdata[15:0]`, and `bus_rdata[31:16]` is 0.
- R5: A read of any word above 7 returns 0000h with `bus_rvalid` set.
- R6: Bits 15:8 of word 0 always read the ID constant 5Ah, whatever was written. Bits 7:0 read 0, including the self-clearing bit 0.
- R7: Writing word 0 with bit 0 set drives `sys_rst` high for exactly the next cycle. Any write in that cycle is dropped. After the pulse, words 2 to 6 read 0000h.
- R8: The software reset pulse leaves the bridge-mode word and the `bridge_mode` output unchanged.
- R9: Entries of the indirect table keep their values through a software reset and through a pin reset.
- R10: A write to word 7 stores the data at the entry selected by word 6. Busy (word 6, bit 15) reads 1 on the cycle right after that write and 0 afterwards. A read of word 7 returns the selected entry, including an entry whose write is still pending.
- R11: The `bridge_mode` output and the `cfg_word` output (general word n in bits 16n+15:16n) always mirror the register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset pin, active low, asynchronous |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data (low 16 bits used) |
| bus_be | input | 4 | Byte enables; any set bit enables the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, upper half zero |
| bus_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| bridge_mode | output | 16 | Bridge-mode word |
| cfg_word | output | 64 | General configuration words 0 to 3 |
| sys_rst | output | 1 | Combined system reset to the chip |

## Verification
Suppose the software-reset pulse is lost, stretched or misrouted. The result shows up at the ports within one cycle. `sys_rst` stays high or never rises, the general words read back nonzero, or the bridge-mode word drops to zero. A wrong staging state in the indirect path shows up on the very next read of word 6 as a wrong busy bit. A read of word 7 then returns a stale entry. An entry lost to a reset only shows up when that index is selected and read again. For that reason the bench revisits the same entries after each kind of reset.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  localparam int unsigned REG_W      = 16;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned MRID_OFF   = 0;
  localparam int unsigned BRIDGE_OFF = 1;
  localparam int unsigned GEN_BASE   = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MRID,
    SEL_BRIDGE,
    SEL_GEN,
    SEL_IADDR,
    SEL_IDATA
  } reg_sel_e;

  function automatic reg_sel_e decode_reg(int unsigned a, int unsigned num_gen);
    if (a == MRID_OFF)                                  return SEL_MRID;
    else if (a == BRIDGE_OFF)                           return SEL_BRIDGE;
    else if (a >= GEN_BASE && a < GEN_BASE + num_gen)   return SEL_GEN;
    else if (a == GEN_BASE + num_gen)                   return SEL_IADDR;
    else if (a == GEN_BASE + num_gen + 1)               return SEL_IDATA;
    else                                                return SEL_NONE;
  endfunction

  function automatic logic access_enabled(logic [3:0] be);
    return |be;
  endfunction

  function automatic logic [REG_W-1:0] id_word(logic [7:0] id);
    return {id, 8'h00};
  endfunction

endpackage

// File: rtl/cfg_reset_ctrl.sv
module cfg_reset_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic swrst_req_i,
  output logic swrst_o,
  output logic sys_rst_o
);

  logic swrst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) swrst_q <= 1'b0;
    else        swrst_q <= swrst_req_i;
  end

  assign swrst_o   = swrst_q;
  assign sys_rst_o = !rst_n || swrst_q;

  // R7
  swrst_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_q |=> !swrst_q);

endmodule

// File: rtl/cfg_direct_regs.sv
module cfg_direct_regs
  import cfgbank_pkg::*;
#(
  parameter int unsigned NUM_GEN = 4,
  parameter int unsigned IDX_W   = 4,
  localparam int unsigned GIDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           swrst_i,
  input  logic                           wr_i,
  input  reg_sel_e                       sel_i,
  input  logic [GIDX_W-1:0]              gen_idx_i,
  input  logic [REG_W-1:0]               wdata_i,
  output logic [REG_W-1:0]               bridge_o,
  output logic [NUM_GEN-1:0][REG_W-1:0]  gen_o,
  output logic [IDX_W-1:0]               iaddr_o
);

  logic [REG_W-1:0] bridge_q;
  logic [IDX_W-1:0] iaddr_q;
  logic [NUM_GEN-1:0][REG_W-1:0] gen_q;

  // bridge-mode word: cleared by the pin only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         bridge_q <= '0;
    else if (wr_i && sel_i == SEL_BRIDGE) bridge_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          iaddr_q <= '0;
    else if (swrst_i)                    iaddr_q <= '0;
    else if (wr_i && sel_i == SEL_IADDR) iaddr_q <= wdata_i[IDX_W-1:0];
  end

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       gen_q[g] <= '0;
      else if (swrst_i) gen_q[g] <= '0;
      else if (wr_i && sel_i == SEL_GEN && gen_idx_i == GIDX_W'(g))
        gen_q[g] <= wdata_i;
    end
  end

  assign bridge_o = bridge_q;
  assign gen_o    = gen_q;
  assign iaddr_o  = iaddr_q;

  // R7
  swrst_clears_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_i |=> (gen_q == '0 && iaddr_q == '0));

  // R8
  bridge_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_i |=> $stable(bridge_q));

endmodule

// File: rtl/cfg_indirect_mem.sv
module cfg_indirect_mem
  import cfgbank_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             busy_o
);

  logic [REG_W-1:0] mem [DEPTH];
  logic             pend_q;
  logic [IDX_W-1:0] stg_idx_q;
  logic [REG_W-1:0] stg_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      stg_idx_q  <= '0;
      stg_data_q <= '0;
    end else begin
      pend_q <= wr_i;
      if (wr_i) begin
        stg_idx_q  <= idx_i;
        stg_data_q <= wdata_i;
      end
    end
  end

  // storage itself has no reset of any kind
  always_ff @(posedge clk) begin
    if (pend_q) mem[stg_idx_q] <= stg_data_q;
  end

  assign rdata_o = (pend_q && stg_idx_q == idx_i) ? stg_data_q : mem[idx_i];
  assign busy_o  = pend_q;

  // R10
  busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> busy_o);

  // R10
  busy_only_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> !busy_o);

endmodule

// File: rtl/cfg_host_regfile.sv
module cfg_host_regfile
  import cfgbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned NUM_GEN   = 4,
  parameter int unsigned IND_DEPTH = 16,
  parameter logic [7:0]  ID_CODE   = 8'h5A
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  input  logic [3:0]               bus_be,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  output logic [15:0]              bridge_mode,
  output logic [NUM_GEN*16-1:0]    cfg_word,
  output logic                     sys_rst
);

  localparam int unsigned IDX_W  = $clog2(IND_DEPTH);
  localparam int unsigned GIDX_W = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;

  reg_sel_e                      sel;
  logic                          acc_ok, wr_fire, rd_fire, swrst_req, swrst, ind_wr;
  logic [ADDR_W-1:0]             gen_off;
  logic [GIDX_W-1:0]             gen_idx;
  logic [REG_W-1:0]              bridge_q, ind_rdata, rd_word;
  logic [NUM_GEN-1:0][REG_W-1:0] gen_q;
  logic [IDX_W-1:0]              iaddr_q;
  logic                          ind_busy;
  logic                          unused_hi;

  assign unused_hi = ^bus_wdata[31:16];

  assign sel       = decode_reg(32'(bus_addr), NUM_GEN);
  assign gen_off   = bus_addr - ADDR_W'(GEN_BASE);
  assign gen_idx   = gen_off[GIDX_W-1:0];
  assign acc_ok    = access_enabled(bus_be);
  assign wr_fire   = bus_wr && acc_ok && !swrst;
  assign rd_fire   = bus_rd && acc_ok;
  assign swrst_req = wr_fire && sel == SEL_MRID && bus_wdata[0];
  assign ind_wr    = wr_fire && sel == SEL_IDATA;

  cfg_reset_ctrl u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .swrst_req_i(swrst_req),
    .swrst_o    (swrst),
    .sys_rst_o  (sys_rst)
  );

  cfg_direct_regs #(.NUM_GEN(NUM_GEN), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .swrst_i  (swrst),
    .wr_i     (wr_fire),
    .sel_i    (sel),
    .gen_idx_i(gen_idx),
    .wdata_i  (bus_wdata[REG_W-1:0]),
    .bridge_o (bridge_q),
    .gen_o    (gen_q),
    .iaddr_o  (iaddr_q)
  );

  cfg_indirect_mem #(.DEPTH(IND_DEPTH)) u_ind (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (ind_wr),
    .idx_i  (iaddr_q),
    .wdata_i(bus_wdata[REG_W-1:0]),
    .rdata_o(ind_rdata),
    .busy_o (ind_busy)
  );

  always_comb begin
    unique case (sel)
      SEL_MRID:   rd_word = id_word(ID_CODE);
      SEL_BRIDGE: rd_word = bridge_q;
      SEL_GEN:    rd_word = gen_q[gen_idx];
      SEL_IADDR:  rd_word = {ind_busy, {(REG_W-1-IDX_W){1'b0}}, iaddr_q};
      SEL_IDATA:  rd_word = ind_rdata;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_fire;
      bus_rdata  <= rd_fire ? {16'h0000, rd_word} : '0;
    end
  end

  assign bridge_mode = bridge_q;
  assign cfg_word    = gen_q;

  // R4
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> (bus_rvalid && bus_rdata[31:16] == 16'h0000));

  // R3
  no_enable_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !acc_ok) |=> !bus_rvalid);

  // R5
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel == SEL_NONE) |=> bus_rdata == 32'h0);

  // R6
  id_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && sel == SEL_MRID) |=> (bus_rdata[15:8] == ID_CODE && bus_rdata[7:0] == 8'h00));

  // R7
  sysrst_on_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |=> sys_rst);

endmodule

// File: tb/cfg_host_regfile_tb.sv
module cfg_host_regfile_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] bridge_mode;
  logic [63:0] cfg_word;
  logic        sys_rst;

  int n_tests = 0;
  int n_fail  = 0;

  logic [15:0] m_bridge;
  logic [15:0] m_gen [4];
  logic [3:0]  m_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_host_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bridge_mode(bridge_mode), .cfg_word(cfg_word),
    .sys_rst(sys_rst)
  );

  function automatic logic [15:0] exp_word(int a);
    if (a == 0)               return 16'h5A00;
    else if (a == 1)          return m_bridge;
    else if (a >= 2 && a < 6) return m_gen[a-2];
    else if (a == 6)          return {12'h000, m_idx};
    else                      return 16'h0000;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d, input logic [3:0] be);
    bus_addr = 6'(a); bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic bus_read(input int a, input logic [3:0] be, output logic [31:0] d, output logic v);
    bus_addr = 6'(a); bus_be = be; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; v = bus_rvalid;
    bus_rd = 1'b0; bus_be = '0;
  endtask

  task automatic read_check(input int a, input logic [15:0] exp, input string req);
    logic [31:0] d; logic v;
    bus_read(a, 4'b1111, d, v);
    check(v && d == {16'h0000, exp}, req, d, {16'h0000, exp});
  endtask

  task automatic clear_model();
    m_bridge = '0; m_idx = '0;
    for (int i = 0; i < 4; i++) m_gen[i] = '0;
  endtask

  task automatic pin_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(sys_rst == 1'b1, "R1 sys_rst during pin reset", 32'(sys_rst), 32'h1);
    check(bus_rvalid == 1'b0, "R1 rvalid in reset", 32'(bus_rvalid), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    clear_model();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v; int r, a, op; logic [3:0] be; logic [31:0] wd;
    void'($urandom(32'd2024));
    clear_model();
    pin_reset();

    // R1 reset values
    for (int i = 0; i < 7; i++) read_check(i, exp_word(i), "R1 reset value");

    // R2 partial byte enable writes all 16 bits, upper data ignored
    bus_write(2, 32'hABCD_1234, 4'b0001); m_gen[0] = 16'h1234;
    read_check(2, 16'h1234, "R2 full word write");
    bus_write(5, 32'hFFFF_9A0B, 4'b1000); m_gen[3] = 16'h9A0B;
    read_check(5, 16'h9A0B, "R2 upper be only");
    // R11 outputs mirror
    check(cfg_word[15:0] == 16'h1234 && cfg_word[63:48] == 16'h9A0B, "R11 cfg_word mirror",
          32'(cfg_word[15:0]), 32'h1234);

    // R3 zero byte enables
    bus_write(2, 32'h0000_5555, 4'b0000);
    read_check(2, 16'h1234, "R3 write without enables");
    bus_read(2, 4'b0000, d, v);
    check(v == 1'b0, "R3 read without enables", 32'(v), 32'h0);

    // R6 ID ignores writes
    bus_write(0, 32'h0000_FFFE, 4'b1111);
    read_check(0, 16'h5A00, "R6 ID field");

    // R5 unmapped
    read_check(40, 16'h0000, "R5 unmapped read");
    read_check(63, 16'h0000, "R5 unmapped top");

    // R10 indirect access and busy
    bus_write(6, 32'h3, 4'b0010); m_idx = 4'h3;
    bus_write(7, 32'hBEEF, 4'b0100);
    read_check(6, 16'h8003, "R10 busy set after data write");
    read_check(6, 16'h0003, "R10 busy cleared");
    read_check(7, 16'hBEEF, "R10 entry readback");
    bus_write(6, 32'h9, 4'b0001); m_idx = 4'h9;
    bus_write(7, 32'h1357, 4'b0001);
    read_check(7, 16'h1357, "R10 read of pending entry");

    // random traffic on mapped and unmapped words
    for (int k = 0; k < 400; k++) begin
      r  = int'($urandom % 16);
      a  = (r < 5) ? r + 1 : ((r < 8) ? 0 : 8 + r * 3);
      op = int'($urandom % 2);
      be = 4'($urandom % 16);
      wd = $urandom;
      if (a == 0) wd[0] = 1'b0;
      if (op == 0) begin
        bus_write(a, wd, be);
        if (be != 0 && a == 1) m_bridge = wd[15:0];
        if (be != 0 && a >= 2 && a < 6) m_gen[a-2] = wd[15:0];
      end else begin
        bus_read(a, be, d, v);
        if (be == 0) check(v == 1'b0, "R3 random read no enables", 32'(v), 32'h0);
        else check(v && d == {16'h0000, exp_word(a)}, "R2/R4/R5 random read", d, {16'h0000, exp_word(a)});
      end
    end
    check(bridge_mode == m_bridge, "R11 bridge_mode mirror", 32'(bridge_mode), 32'(m_bridge));

    // R7 / R8 software reset
    bus_write(1, 32'h00C3, 4'b1111); m_bridge = 16'h00C3;
    bus_write(3, 32'h4444, 4'b1111);
    bus_write(6, 32'h3, 4'b1111);
    bus_write(0, 32'h0001, 4'b0001);
    check(sys_rst == 1'b1, "R7 pulse high", 32'(sys_rst), 32'h1);
    bus_write(4, 32'h7777, 4'b1111);
    check(sys_rst == 1'b0, "R7 pulse one cycle", 32'(sys_rst), 32'h0);
    for (int i = 0; i < 4; i++) m_gen[i] = '0;
    m_idx = '0;
    read_check(3, 16'h0000, "R7 general cleared");
    read_check(4, 16'h0000, "R7 write during pulse dropped");
    read_check(6, 16'h0000, "R7 index cleared");
    read_check(0, 16'h5A00, "R6 R7 control bit reads zero");
    read_check(1, 16'h00C3, "R8 bridge kept");
    check(bridge_mode == 16'h00C3, "R8 bridge_mode port", 32'(bridge_mode), 32'h00C3);

    // R9 indirect survives both resets
    bus_write(6, 32'h3, 4'b1111);
    read_check(7, 16'hBEEF, "R9 entry after software reset");
    pin_reset();
    read_check(1, 16'h0000, "R1 bridge cleared by pin");
    bus_write(6, 32'h9, 4'b1111);
    read_check(7, 16'h1357, "R9 entry after pin reset");
    bus_write(6, 32'h3, 4'b1111);
    read_check(7, 16'hBEEF, "R9 second entry after pin reset");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule